// File: doc/BRIEF.md
# Latched-Address One-Time-Programmable Memory

A synthesizable behavioural model of a 2048-word by 8-bit fuse memory. A read starts when the active-low chip enable falls. The address present at that clock edge is held inside the block, and the word at that address appears on the data bus a fixed number of clock cycles later. The bus is driven only while chip enable and a separate active-low output enable are both asserted. Before the read latency has passed, the data value is undefined.

Every bit starts at 0. A bit can be set to 1 once, and it never returns to 0. Programming is modelled digitally. The block is in programming mode when the active-low program select is asserted, output enable is deasserted, and a flag reports that the supply is in its high state. In that mode, a request to pull one data line low, held long enough, sets that bit in the word at the latched address. A pulse that is too short changes nothing, so a programmer can verify the word and retry. A request on several lines at once raises an error flag and programs nothing.

A parameter list can preload selected words, so a test can start from a partly programmed array.

Top module: `otp_latched_mem`

## Requirements
- R1: The array holds 2^AW words (AW=11) of DW bits (DW=8). An unprogrammed word reads as all zeros. A word named in the preload list PRE_LIST reads as its listed value. Each list entry is {address[AW-1:0], data[DW-1:0]}, and entry i occupies bits [i*(AW+DW) +: AW+DW].
- R2: A stored bit never changes from 1 to 0. Programming ORs the pulsed bit into the existing word.
- R3: The address is captured at the first rising clock edge at which ce_n is sampled low after being sampled high. Later changes of addr have no effect on the word read until ce_n rises and falls again.
- R4: dout_en is 1 exactly when ce_n and oe_n are both 0, and 0 otherwise.
- R5: dout shows the latched word from the RD_LAT-th rising edge onward, counting the capture edge as the first, while ce_n stays low.
- R6: A bit is programmed only while prog_n=0, oe_n=1 and hv_on=1. Pulses given under any other combination leave the array unchanged.
- R7: In programming mode, if exactly one bit of pull_lo is 1 and is held for MIN_PW consecutive rising edges, the matching bit of the word at the latched address becomes 1. Bit k of pull_lo corresponds to bit k of the data word.
- R8: A single-bit pulse held for fewer than MIN_PW edges leaves the word unchanged.
- R9: In programming mode, when more than one bit of pull_lo is 1, err is 1 after the next rising edge and no bit is programmed. err is 0 once the condition is gone.
- R10: During and right after reset, dout_en follows its inputs (0 while ce_n=1) and err is 0. The array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| addr | input | AW | Word address, captured when chip enable falls |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| prog_n | input | 1 | Active-low program select |
| hv_on | input | 1 | High programming supply present |
| pull_lo | input | DW | Per-bit request to pull a data line low (programming pulse) |
| dout | output | DW | Read data |
| dout_en | output | 1 | Data bus drive enable |
| err | output | 1 | More than one pull-low request in programming mode |

## Verification
The bench builds the block with RD_LAT=3, MIN_PW=5 and a two-entry preload: A5 at word 0x005 and 3C at the top word 0x7FF. A latency above two leaves room to move the address inside the read window and show that the change is ignored. With MIN_PW at 5, the bench can give both a four-edge pulse that must fail and a five-edge pulse that must succeed. The preloaded words make reads of programmed data, the highest address, and ORing new bits into an existing word reachable without first programming them.

// File: rtl/otp_latched_mem.sv
module otp_latched_mem #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int RD_LAT = 2,
  parameter int MIN_PW = 4,
  parameter int PRE_N = 1,
  parameter logic [PRE_N*(AW+DW)-1:0] PRE_LIST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          prog_n,
  input  logic          hv_on,
  input  logic [DW-1:0] pull_lo,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          err
);
  localparam int DEPTH = 1 << AW;
  localparam int EW = AW + DW;
  localparam int RW = $clog2(RD_LAT + 1);
  localparam int PW = $clog2(MIN_PW + 1);

  logic [DW-1:0] fuse [DEPTH];
  logic          ce_q;
  logic [AW-1:0] addr_lat;
  logic [RW-1:0] rd_cnt;
  logic [PW-1:0] pw_cnt;
  logic [DW-1:0] pw_bit;
  logic          err_q;

  initial for (int i = 0; i < DEPTH; i++) fuse[i] = '0;

  function automatic logic [DW-1:0] pre_word(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    w = '0;
    for (int i = 0; i < PRE_N; i++)
      if (PRE_LIST[i*EW+DW +: AW] == a) w = w | PRE_LIST[i*EW +: DW];
    return w;
  endfunction

  wire ce_fall   = ce_q & ~ce_n;
  wire prog_mode = ~prog_n & oe_n & hv_on;
  wire one_req   = $onehot(pull_lo);
  wire multi_req = (pull_lo & (pull_lo - 1'b1)) != '0;
  wire same_req  = one_req && (pull_lo == pw_bit);
  wire fire      = prog_mode && same_req && (pw_cnt == PW'(MIN_PW - 1));
  wire rd_vld    = ~ce_n && (rd_cnt == RW'(RD_LAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q     <= 1'b1;
      addr_lat <= '0;
      rd_cnt   <= '0;
      pw_cnt   <= '0;
      pw_bit   <= '0;
      err_q    <= 1'b0;
    end else begin
      ce_q  <= ce_n;
      err_q <= prog_mode & multi_req;
      if (ce_fall) addr_lat <= addr;
      if (ce_fall) rd_cnt <= RW'(1);
      else if (ce_n) rd_cnt <= '0;
      else if (rd_cnt < RW'(RD_LAT)) rd_cnt <= rd_cnt + 1'b1;
      if (!prog_mode || !one_req) begin
        pw_cnt <= '0;
        pw_bit <= '0;
      end else if (!same_req) begin
        pw_cnt <= PW'(1);
        pw_bit <= pull_lo;
      end else if (pw_cnt != PW'(MIN_PW)) begin
        pw_cnt <= pw_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (fire) fuse[addr_lat] <= fuse[addr_lat] | pull_lo;

  assign dout_en = ~ce_n & ~oe_n;
  assign dout    = rd_vld ? (fuse[addr_lat] | pre_word(addr_lat)) : {DW{1'bx}};
  assign err     = err_q;
endmodule

module otp_latched_mem_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          prog_n,
  input logic          hv_on,
  input logic [DW-1:0] pull_lo,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic          err,
  input logic          rd_vld,
  input logic          fire,
  input logic [AW-1:0] addr_lat
);
  // R4
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!oe_n && !ce_n));
  // R2
  no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && $past(rd_vld) && $stable(addr_lat)) |-> (($past(dout) & ~dout) == '0));
  // R3
  latch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_lat) |-> ($past(ce_n) == 1'b0));
  // R6
  prog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (!prog_n && oe_n && hv_on));
  // R7
  single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $onehot(pull_lo));
  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(!prog_n && hv_on && oe_n && ($countones(pull_lo) > 1)));
  // R9
  err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !($countones(pull_lo) > 1));
endmodule

bind otp_latched_mem otp_latched_mem_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/otp_latched_mem_tb_top.sv
`timescale 1ns/1ps
module otp_latched_mem_tb_top;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int RD_LAT = 3;
  localparam int MIN_PW = 5;
  localparam logic [2*(AW+DW)-1:0] PRE = {11'h7FF, 8'h3C, 11'h005, 8'hA5};
  localparam int NV = 6;
  localparam logic [AW+DW-1:0] VEC [NV] = '{
    {11'h005, 8'hA5}, {11'h7FF, 8'h3C}, {11'h000, 8'h00},
    {11'h400, 8'h00}, {11'h123, 8'h00}, {11'h7FE, 8'h00}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, prog_n = 1'b1, hv_on = 1'b0;
  logic [DW-1:0] pull_lo = '0;
  logic [DW-1:0] dout;
  logic dout_en, err;
  int nchk = 0, nfail = 0;
  logic err_seen;

  always #10 clk = ~clk;

  otp_latched_mem #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT), .MIN_PW(MIN_PW),
    .PRE_N(2), .PRE_LIST(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .prog_n(prog_n), .hv_on(hv_on), .pull_lo(pull_lo), .dout(dout),
    .dout_en(dout_en), .err(err));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [AW-1:0] a2,
                    input logic [DW-1:0] exp, input string tag);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; addr = a;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); addr = a2;
    repeat (RD_LAT - 1) @(posedge clk);
    @(negedge clk);
    chk({tag, " en"}, {7'd0, dout_en}, 8'd1);
    chk(tag, dout, exp);
    ce_n = 1'b1;
  endtask

  task automatic pgm(input logic [AW-1:0] a, input logic [DW-1:0] mask, input int cyc,
                     input logic hv, input logic oe, input logic pn);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; addr = a;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); prog_n = pn; hv_on = hv; oe_n = oe; pull_lo = mask;
    repeat (cyc) @(posedge clk);
    @(negedge clk); err_seen = err;
    pull_lo = '0; prog_n = 1'b1; hv_on = 1'b0; oe_n = 1'b1; ce_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 dout_en in reset", {7'd0, dout_en}, 8'd0);
    chk("R10 err in reset", {7'd0, err}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 err after reset", {7'd0, err}, 8'd0);

    // R1 R5 table of reads
    for (int i = 0; i < NV; i++)
      rd(VEC[i][AW+DW-1:DW], VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], "R1 R5 table read");

    // R4 output enable gating
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk); chk("R4 oe_n high", {7'd0, dout_en}, 8'd0);
    oe_n = 1'b0; #1 chk("R4 both low", {7'd0, dout_en}, 8'd1);
    ce_n = 1'b1; #1 chk("R4 ce_n high", {7'd0, dout_en}, 8'd0);

    // R3 address change after the falling edge is ignored
    rd(11'h005, 11'h7FF, 8'hA5, "R3 late addr change");

    // R8 short pulse, then R7 full pulse, then retry on another bit
    pgm(11'h010, 8'h04, MIN_PW - 1, 1'b1, 1'b1, 1'b0);
    rd(11'h010, 11'h010, 8'h00, "R8 short pulse");
    pgm(11'h010, 8'h04, MIN_PW, 1'b1, 1'b1, 1'b0);
    rd(11'h010, 11'h010, 8'h04, "R7 full pulse");
    pgm(11'h010, 8'h80, MIN_PW + 3, 1'b1, 1'b1, 1'b0);
    rd(11'h010, 11'h010, 8'h84, "R7 second bit");

    // R9 multi-bit request
    pgm(11'h020, 8'h03, MIN_PW + 2, 1'b1, 1'b1, 1'b0);
    chk("R9 err raised", {7'd0, err_seen}, 8'd1);
    @(negedge clk);
    chk("R9 err cleared", {7'd0, err}, 8'd0);
    rd(11'h020, 11'h020, 8'h00, "R9 nothing programmed");

    // R6 missing qualifiers
    pgm(11'h030, 8'h01, MIN_PW + 1, 1'b0, 1'b1, 1'b0);
    rd(11'h030, 11'h030, 8'h00, "R6 no high supply");
    pgm(11'h030, 8'h01, MIN_PW + 1, 1'b1, 1'b0, 1'b0);
    rd(11'h030, 11'h030, 8'h00, "R6 output enabled");
    pgm(11'h030, 8'h01, MIN_PW + 1, 1'b1, 1'b1, 1'b1);
    rd(11'h030, 11'h030, 8'h00, "R6 program select off");

    // R2 ORing into a preloaded word; existing ones stay
    pgm(11'h005, 8'h01, MIN_PW, 1'b1, 1'b1, 1'b0);
    rd(11'h005, 11'h005, 8'hA5, "R2 set bit already 1");
    pgm(11'h005, 8'h02, MIN_PW, 1'b1, 1'b1, 1'b0);
    rd(11'h005, 11'h005, 8'hA7, "R2 OR into word");

    // R10 reset keeps contents
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(11'h010, 11'h010, 8'h84, "R10 contents survive reset");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule